// File: doc/BRIEF.md
# Sector Program/Erase Guard

This block decides whether a program or erase request aimed at one sector of a sixteen-sector nonvolatile array may go ahead. It holds a small register file with two software-controlled lock bits per sector: a write lock that refuses program and erase, and a read lock that hides array data. Two active-low hardware protect pins add further protection. One pin covers only the highest sector. The other covers every remaining sector. Neither pin can remove a register lock.

A request is presented for one cycle with its target sector. One cycle later the guard raises either a one-cycle grant or a one-cycle reject. A device-level reset indicator and a low-supply flag each refuse every request while they are active. The reset indicator also returns all lock bits to their locked default. On the read side, data from a read-locked sector is replaced by zero before it reaches the bus front-end.

Top module: `sector_guard`

## Requirements
- R1: After `rst_ni` is released, and in the cycle after `hold_reset_i` is sampled high, every sector reads back `cfg_rdata_o == 2'b11` (both locks set). `grant_o` and `reject_o` are low while `rst_ni` is low.
- R2: When `top_lock_ni` is low, a request to sector 15 is rejected, whatever the lock registers hold.
- R3: When `wp_ni` is low, a request to any sector 0 to 14 is rejected, whatever the lock registers hold.
- R4: When the pin covering a sector is high, that sector's write-lock bit alone decides the outcome. Pin levels never change the lock register contents as read back through `cfg_rdata_o`.
- R5: A request sampled at a rising edge yields `grant_o` high for exactly the following cycle when all of these hold: the covering pin is high, the sector's write lock is clear, `hold_reset_i` is low and `low_vcc_i` is low.
- R6: Every request sampled without a grant yields `reject_o` high for exactly the following cycle. `grant_o` and `reject_o` are never high together. Both stay low in the cycle after a cycle with no request.
- R7: A request sampled while `hold_reset_i` or `low_vcc_i` is high is rejected.
- R8: `rd_data_o` is zero when the read-lock bit of `rd_sector_i` is set. Otherwise it equals `rd_array_i`, with no clock delay.
- R9: A lock write with `cfg_we_i` high stores `cfg_wdata_i[1]` as the read lock and `cfg_wdata_i[0]` as the write lock of `cfg_sector_i`. The new value governs requests from the next cycle on. `cfg_rdata_o` returns {read lock, write lock} of `cfg_sector_i` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hold_reset_i | input | 1 | Device reset indicator, synchronous, active high |
| low_vcc_i | input | 1 | Supply below lockout threshold |
| top_lock_ni | input | 1 | Hardware protect for the top sector, active low |
| wp_ni | input | 1 | Hardware protect for all other sectors, active low |
| cfg_we_i | input | 1 | Lock register write strobe |
| cfg_sector_i | input | 4 | Lock register sector select |
| cfg_wdata_i | input | 2 | {read lock, write lock} write data |
| cfg_rdata_o | output | 2 | {read lock, write lock} of selected sector |
| req_valid_i | input | 1 | Program/erase request |
| req_sector_i | input | 4 | Target sector of request |
| grant_o | output | 1 | Request granted (one cycle) |
| reject_o | output | 1 | Request rejected (one cycle) |
| rd_sector_i | input | 4 | Sector of current array read |
| rd_array_i | input | 8 | Raw array read data |
| rd_data_o | output | 8 | Read data after read-lock masking |

## Verification
The assertions check on every cycle that grant and reject are exclusive, that both appear only after a request, and that low supply, an active top-lock pin on sector 15 and an active write-protect pin on the lower sectors never lead to a grant. They also check that the reset indicator leaves every write lock set. Only the bench scenarios can show that each outcome is correct. The bench sweeps every sector against every pin combination, both lock polarities and the supply flag. It also confirms that pin activity leaves the read-back lock contents unchanged and that read masking follows each sector's own read lock.

// File: rtl/sg_pkg.sv
package sg_pkg;
  typedef struct packed {
    logic rd_lock;
    logic wr_lock;
  } lock_t;

  localparam lock_t LOCK_DEFAULT = '{rd_lock: 1'b1, wr_lock: 1'b1};
endpackage

// File: rtl/sg_lock_regs.sv
module sg_lock_regs
  import sg_pkg::*;
#(
  parameter int NUM_SECTORS = 16,
  parameter int SEC_W       = $clog2(NUM_SECTORS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clr_i,
  input  logic                   we_i,
  input  logic [SEC_W-1:0]       wsec_i,
  input  lock_t                  wdata_i,
  output logic [NUM_SECTORS-1:0] wr_lock_o,
  output logic [NUM_SECTORS-1:0] rd_lock_o
);
  for (genvar g = 0; g < NUM_SECTORS; g++) begin : g_sec
    lock_t lock_q;
    logic  hit;
    assign hit = we_i && (wsec_i == SEC_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     lock_q <= LOCK_DEFAULT;
      else if (clr_i)  lock_q <= LOCK_DEFAULT;
      else if (hit)    lock_q <= wdata_i;
    end

    assign wr_lock_o[g] = lock_q.wr_lock;
    assign rd_lock_o[g] = lock_q.rd_lock;
  end

  AST_CLR_LOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (&wr_lock_o) && (&rd_lock_o)); // R1
  AST_HOLD_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && !clr_i) |=> $stable(wr_lock_o) && $stable(rd_lock_o)); // R4
endmodule

// File: rtl/sg_grant.sv
module sg_grant #(
  parameter int NUM_SECTORS = 16,
  parameter int SEC_W       = $clog2(NUM_SECTORS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  input  logic [SEC_W-1:0]       req_sector_i,
  input  logic [NUM_SECTORS-1:0] wr_lock_i,
  input  logic                   top_lock_ni,
  input  logic                   wp_ni,
  input  logic                   hold_reset_i,
  input  logic                   low_vcc_i,
  output logic                   grant_o,
  output logic                   reject_o
);
  localparam logic [SEC_W-1:0] TOP_SEC = SEC_W'(NUM_SECTORS - 1);

  logic in_range, is_top, hw_block, sw_block, env_block, ok;

  assign in_range  = 32'(req_sector_i) < NUM_SECTORS;
  assign is_top    = req_sector_i == TOP_SEC;
  // each pin only adds protection over its own range
  assign hw_block  = is_top ? !top_lock_ni : !wp_ni;
  assign sw_block  = !in_range || wr_lock_i[req_sector_i];
  assign env_block = hold_reset_i || low_vcc_i;
  assign ok        = !hw_block && !sw_block && !env_block;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_o  <= 1'b0;
      reject_o <= 1'b0;
    end else begin
      grant_o  <= req_valid_i && ok;
      reject_o <= req_valid_i && !ok;
    end
  end

  AST_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(grant_o && reject_o)); // R6
  AST_NO_REQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !grant_o && !reject_o); // R6
  AST_REQ_ANSWERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> grant_o || reject_o); // R6
  AST_ENV_REFUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && (low_vcc_i || hold_reset_i) |=> reject_o); // R7
  AST_TOP_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && is_top && !top_lock_ni |=> !grant_o); // R2
  AST_WP_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !is_top && !wp_ni |=> !grant_o); // R3
endmodule

// File: rtl/sg_read_mask.sv
module sg_read_mask #(
  parameter int NUM_SECTORS = 16,
  parameter int SEC_W       = $clog2(NUM_SECTORS),
  parameter int DATA_W      = 8
) (
  input  logic [SEC_W-1:0]       rd_sector_i,
  input  logic [NUM_SECTORS-1:0] rd_lock_i,
  input  logic [DATA_W-1:0]      rd_array_i,
  output logic [DATA_W-1:0]      rd_data_o
);
  logic hide;
  assign hide      = (32'(rd_sector_i) >= NUM_SECTORS) || rd_lock_i[rd_sector_i];
  assign rd_data_o = hide ? '0 : rd_array_i;
endmodule

// File: rtl/sector_guard.sv
module sector_guard
  import sg_pkg::*;
#(
  parameter int NUM_SECTORS = 16,
  parameter int DATA_W      = 8,
  localparam int SEC_W      = $clog2(NUM_SECTORS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hold_reset_i,
  input  logic              low_vcc_i,
  input  logic              top_lock_ni,
  input  logic              wp_ni,
  input  logic              cfg_we_i,
  input  logic [SEC_W-1:0]  cfg_sector_i,
  input  logic [1:0]        cfg_wdata_i,
  output logic [1:0]        cfg_rdata_o,
  input  logic              req_valid_i,
  input  logic [SEC_W-1:0]  req_sector_i,
  output logic              grant_o,
  output logic              reject_o,
  input  logic [SEC_W-1:0]  rd_sector_i,
  input  logic [DATA_W-1:0] rd_array_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [NUM_SECTORS-1:0] wr_lock, rd_lock;
  lock_t                  wdata;

  assign wdata = '{rd_lock: cfg_wdata_i[1], wr_lock: cfg_wdata_i[0]};

  sg_lock_regs #(.NUM_SECTORS(NUM_SECTORS), .SEC_W(SEC_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (hold_reset_i),
    .we_i     (cfg_we_i),
    .wsec_i   (cfg_sector_i),
    .wdata_i  (wdata),
    .wr_lock_o(wr_lock),
    .rd_lock_o(rd_lock)
  );

  assign cfg_rdata_o = (32'(cfg_sector_i) < NUM_SECTORS)
                     ? {rd_lock[cfg_sector_i], wr_lock[cfg_sector_i]} : 2'b11;

  sg_grant #(.NUM_SECTORS(NUM_SECTORS), .SEC_W(SEC_W)) u_grant (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_sector_i(req_sector_i),
    .wr_lock_i   (wr_lock),
    .top_lock_ni (top_lock_ni),
    .wp_ni       (wp_ni),
    .hold_reset_i(hold_reset_i),
    .low_vcc_i   (low_vcc_i),
    .grant_o     (grant_o),
    .reject_o    (reject_o)
  );

  sg_read_mask #(.NUM_SECTORS(NUM_SECTORS), .SEC_W(SEC_W), .DATA_W(DATA_W)) u_mask (
    .rd_sector_i(rd_sector_i),
    .rd_lock_i  (rd_lock),
    .rd_array_i (rd_array_i),
    .rd_data_o  (rd_data_o)
  );

  AST_LOCKED_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && wr_lock[req_sector_i] |=> !grant_o); // R4
endmodule

// File: tb/sim_sector_guard.sv
module sim_sector_guard;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hold_reset = 1'b0, low_vcc = 1'b0, top_n = 1'b1, wp_n = 1'b1;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_sector = '0;
  logic [1:0] cfg_wdata = '0;
  logic [1:0] cfg_rdata;
  logic req_valid = 1'b0;
  logic [3:0] req_sector = '0;
  logic grant, reject;
  logic [3:0] rd_sector = '0;
  logic [7:0] rd_array = '0;
  logic [7:0] rd_data;

  int checks = 0, errors = 0;
  logic exp_wr [16];
  logic exp_rd [16];

  always #10 clk = ~clk;

  sector_guard u0 (
    .clk_i(clk), .rst_ni(rst_n), .hold_reset_i(hold_reset), .low_vcc_i(low_vcc),
    .top_lock_ni(top_n), .wp_ni(wp_n), .cfg_we_i(cfg_we), .cfg_sector_i(cfg_sector),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata), .req_valid_i(req_valid),
    .req_sector_i(req_sector), .grant_o(grant), .reject_o(reject),
    .rd_sector_i(rd_sector), .rd_array_i(rd_array), .rd_data_o(rd_data)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic cfg_write(input int s, input bit rd, input bit wr);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sector = 4'(s); cfg_wdata = {rd, wr};
    @(negedge clk);
    cfg_we = 1'b0;
    exp_rd[s] = rd; exp_wr[s] = wr;
  endtask

  task automatic check_regs(input string tag);
    for (int s = 0; s < 16; s++) begin
      cfg_sector = 4'(s);
      #1;
      chk(cfg_rdata == {exp_rd[s], exp_wr[s]}, tag, cfg_rdata, {exp_rd[s], exp_wr[s]});
    end
  endtask

  // request at a negedge, sampled at the next posedge, result checked at the negedge after
  task automatic do_req(input int s, input string tag);
    bit hw, exp_g;
    hw    = (s == 15) ? !top_n : !wp_n;
    exp_g = !hw && !exp_wr[s] && !hold_reset && !low_vcc;
    @(negedge clk);
    req_valid = 1'b1; req_sector = 4'(s);
    @(negedge clk);
    req_valid = 1'b0;
    chk(grant == exp_g && reject == !exp_g, tag, {grant, reject}, {exp_g, !exp_g});
    @(negedge clk);
    chk(!grant && !reject, "R6 quiet after request", {grant, reject}, 0);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int s = 0; s < 16; s++) begin exp_wr[s] = 1'b1; exp_rd[s] = 1'b1; end
    repeat (3) @(negedge clk);
    chk(!grant && !reject, "R1 outputs in reset", {grant, reject}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_regs("R1 lock default after reset");
    do_req(3, "R1 default locked rejects");

    // R9 write encoding and R8 read masking
    for (int s = 0; s < 16; s++) cfg_write(s, s[0], s[1]);
    check_regs("R9 lock write readback");
    for (int s = 0; s < 16; s++) begin
      rd_sector = 4'(s); rd_array = 8'hA5 ^ 8'(s * 17);
      #1;
      chk(rd_data == (exp_rd[s] ? 8'h00 : rd_array), "R8 read masking", rd_data,
          exp_rd[s] ? 8'h00 : rd_array);
    end

    // sweep: two lock polarities x pins x supply x all sectors (R2 R3 R4 R5 R7)
    for (int p = 0; p < 2; p++) begin
      for (int s = 0; s < 16; s++) cfg_write(s, 1'b0, 1'((s + p) % 2));
      for (int pins = 0; pins < 4; pins++) begin
        for (int v = 0; v < 2; v++) begin
          @(negedge clk);
          top_n = pins[0]; wp_n = pins[1]; low_vcc = v[0];
          for (int s = 0; s < 16; s++)
            do_req(s, s == 15 ? "R2 R5 top sector outcome" : "R3 R5 lower sector outcome");
        end
        check_regs("R4 pins leave locks unchanged");
      end
    end
    @(negedge clk);
    top_n = 1'b1; wp_n = 1'b1; low_vcc = 1'b0;

    // R9 write becomes effective next cycle: unlock then request back to back
    cfg_write(7, 1'b0, 1'b0);
    do_req(7, "R9 unlocked sector grants next cycle");
    cfg_write(7, 1'b0, 1'b1);
    do_req(7, "R4 relocked sector rejects");

    // R7 and R1: hold_reset refuses and restores locks
    for (int s = 0; s < 16; s++) cfg_write(s, 1'b0, 1'b0);
    @(negedge clk);
    hold_reset = 1'b1;
    do_req(2, "R7 hold_reset rejects");
    @(negedge clk);
    hold_reset = 1'b0;
    for (int s = 0; s < 16; s++) begin exp_wr[s] = 1'b1; exp_rd[s] = 1'b1; end
    check_regs("R1 hold_reset restores locks");
    do_req(2, "R1 relocked after hold_reset");

    finish_run();
  end
endmodule